// File: doc/BRIEF.md
# Array-Style Unsigned Multiplier

This block multiplies two unsigned operands of N bits (four by default) and returns the full 2N-bit product. It does not use a generic multiply operator. It forms one partial-product row per multiplier bit. Each row is the multiplicand gated by that bit. The rows are then accumulated down a chain of adders that grow by one bit per stage, and each new row enters one place further left than the row before it. For the default size the chain is a 5-bit adder, then a 6-bit adder, then a 7-bit adder. The carry out of each adder becomes the top bit of the next running sum.

Every adder in the chain is built from 4-bit carry-lookahead groups. Inside a group, generate is the AND of the operand bits and propagate is their XOR. Each carry is the flattened sum-of-products of the lower generates, gated by the propagates above them. Each sum bit is propagate XOR incoming carry. Between groups the carries ripple.

A parameter selects whether the product is registered. When it is, the block captures the product on a rising clock edge and clears it with an asynchronous active-low reset. This gives a bench or a surrounding pipeline a clean one-cycle timing point. The block has no state machine: the only state is the optional output register.

Top module: `mula_array`

## Requirements
- R1: When the multiplier operand b has exactly one bit set, at position i (value 2^i), the product equals the multiplicand a shifted left by i places, zero-filled.
- R2: For every pair of unsigned operands a and b, the product p equals a times b as an unsigned 2N-bit value; for example 0111 times 1100 gives 01010100.
- R3: When either operand is zero, the product is zero.
- R4: When one operand equals 1, the product equals the other operand, zero-extended to 2N bits.
- R5: With the registered output selected (the default), p shows the product of the operands sampled at the most recent rising clock edge, and it holds that value while the operands change between edges.
- R6: While rst_n is low, the registered product is zero, and it clears as soon as rst_n falls, without waiting for a clock edge.
- R7: The largest operands give the largest product, with the carry out of the widest adder landing in the top product bit (15 times 15 gives 225 for N = 4).
- R8: Carries generated in the low 4-bit lookahead group of an adder reach the bits above the group boundary (for example 15 times 3 gives 45 and 13 times 13 gives 169).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional product register |
| rst_n | input | 1 | Asynchronous active-low reset of the product register |
| a | input | N | Unsigned multiplicand |
| b | input | N | Unsigned multiplier; bit i gates partial-product row i |
| p | output | 2N | Unsigned product |

## Verification
The array is driven with every one of the 256 operand pairs, and each result is compared with an arithmetic product, so any wrong gating, shift or adder width shows up somewhere. Dedicated passes separate the row structure from the adders. A one-hot multiplier isolates a single row and its shift (R1). Zero and unit operands expose stuck or crossed row gating. Full-scale and carry-heavy pairs stress the lookahead carries across the group boundary and into the top product bit. Short sequences also show the one-edge latency, the hold between edges, and the asynchronous clear of the output register.

// File: rtl/mula_pkg.sv
package mula_pkg;
    // Width of one carry-lookahead group
    localparam int CLA_SPAN = 4;

    // Number of lookahead groups needed to cover w bits
    function automatic int grp_count(input int w);
        return (w + CLA_SPAN - 1) / CLA_SPAN;
    endfunction
endpackage

// File: rtl/mula_cla_group.sv
module mula_cla_group #(
    parameter int GW = 4
) (
    input  logic [GW-1:0] x,
    input  logic [GW-1:0] y,
    input  logic          cin,
    output logic [GW-1:0] s,
    output logic          cout
);
    logic [GW-1:0] gen_v;
    logic [GW-1:0] prp_v;
    logic [GW:0]   car_v;
    logic          run_p;

    // Flattened lookahead: carry k+1 is g[k] | p[k]g[k-1] | ... | p[k..0]cin
    always_comb begin
        gen_v = x & y;
        prp_v = x ^ y;
        car_v = '0;
        run_p = 1'b0;
        car_v[0] = cin;
        for (int k = 0; k < GW; k++) begin
            car_v[k+1] = gen_v[k];
            run_p      = prp_v[k];
            for (int j = k - 1; j >= 0; j--) begin
                car_v[k+1] = car_v[k+1] | (run_p & gen_v[j]);
                run_p      = run_p & prp_v[j];
            end
            car_v[k+1] = car_v[k+1] | (run_p & cin);
        end
        s    = prp_v ^ car_v[GW-1:0];
        cout = car_v[GW];
    end
endmodule

// File: rtl/mula_cla_adder.sv
module mula_cla_adder #(
    parameter int W = 5
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int NG = mula_pkg::grp_count(W);

    logic [NG:0] grp_c;

    assign grp_c[0] = cin;

    generate
        for (genvar k = 0; k < NG; k++) begin : grp
            localparam int LO = k * mula_pkg::CLA_SPAN;
            localparam int GW = ((W - LO) < mula_pkg::CLA_SPAN) ? (W - LO) : mula_pkg::CLA_SPAN;
            mula_cla_group #(.GW(GW)) u_grp (
                .x    (a[LO +: GW]),
                .y    (b[LO +: GW]),
                .cin  (grp_c[k]),
                .s    (sum[LO +: GW]),
                .cout (grp_c[k+1])
            );
        end
    endgenerate

    assign cout = grp_c[NG];
endmodule

// File: rtl/mula_pp_row.sv
module mula_pp_row #(
    parameter int N = 4
) (
    input  logic [N-1:0] mcand,
    input  logic         mbit,
    output logic [N-1:0] row
);
    assign row = mcand & {N{mbit}};
endmodule

// File: rtl/mula_array.sv
module mula_array #(
    parameter int N       = 4,
    parameter bit REG_OUT = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   a,
    input  logic [N-1:0]   b,
    output logic [2*N-1:0] p
);
    localparam int PW = 2 * N;

    // Stage i holds a running sum of N+i+1 bits; stage i>0 uses an N+i bit adder
    generate
        for (genvar i = 0; i < N; i++) begin : stg
            logic [N-1:0] row;
            logic [N+i:0] acc;

            mula_pp_row #(.N(N)) u_row (
                .mcand (a),
                .mbit  (b[i]),
                .row   (row)
            );

            if (i == 0) begin : g_first
                assign acc = {1'b0, row};
            end else begin : g_add
                logic [N+i-1:0] addend;
                assign addend = {row, {i{1'b0}}};
                mula_cla_adder #(.W(N + i)) u_add (
                    .a    (stg[i-1].acc),
                    .b    (addend),
                    .cin  (1'b0),
                    .sum  (acc[N+i-1:0]),
                    .cout (acc[N+i])
                );
            end
        end
    endgenerate

    logic [PW-1:0] prod;
    assign prod = stg[N-1].acc;

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    p <= '0;
                end else begin
                    p <= prod;
                end
            end
        end else begin : g_comb
            assign p = prod;
        end
    endgenerate
endmodule

// File: rtl/mula_array_chk.sv
module mula_array_chk #(
    parameter int N       = 4,
    parameter bit REG_OUT = 1'b1
) (
    input logic           clk,
    input logic           rst_n,
    input logic [N-1:0]   a,
    input logic [N-1:0]   b,
    input logic [2*N-1:0] p
);
    localparam int PW = 2 * N;

    generate
        if (REG_OUT) begin : g_reg
            // R2
            prod_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (p == (PW'($past(a)) * PW'($past(b)))));

            // R3
            zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && (($past(a) == '0) || ($past(b) == '0))) |-> (p == '0));

            // R4
            unit_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && ($past(b) == N'(1))) |-> (p == PW'($past(a))));

            // R1
            row_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && ($countones($past(b)) == 1)) |-> ($countones(p) == $countones($past(a))));

            // R6
            rst_clear_chk: assert property (@(posedge clk)
                !rst_n |=> (p == '0));
        end else begin : g_comb
            always_ff @(posedge clk) begin
                if (rst_n) begin
                    // R2
                    comb_prod_chk: assert (p == (PW'(a) * PW'(b)));
                end
            end
        end
    endgenerate
endmodule

bind mula_array mula_array_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .a     (a),
    .b     (b),
    .p     (p)
);

// File: tb/mula_array_tb_top.sv
module mula_array_tb_top;
    logic       clk;
    logic       rst_n;
    logic [3:0] a;
    logic [3:0] b;
    logic [7:0] p;
    int         total;
    int         bad;
    bit         done;

    mula_array #(.N(4), .REG_OUT(1'b1)) dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .a     (a),
        .b     (b),
        .p     (p)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%0d expected=%0d", tag, got, exp);
        end
    endtask

    // Drive operands after a falling edge; one rising edge later the product is visible
    task automatic apply(input int x, input int y);
        @(negedge clk);
        a = 4'(x);
        b = 4'(y);
        @(negedge clk);
    endtask

    initial begin
        total = 0;
        bad   = 0;
        done  = 1'b0;
        rst_n = 1'b0;
        a     = 4'd15;
        b     = 4'd15;
        repeat (3) @(negedge clk);
        check("R6 reset state", p, 8'd0);
        rst_n = 1'b1;

        apply(7, 12);
        check("R2 0111x1100", p, 8'd84);

        // R5: one-edge latency and hold between edges
        apply(3, 5);
        check("R5 first product", p, 8'd15);
        a = 4'd7;
        b = 4'd9;
        #2;
        check("R5 hold before edge", p, 8'd15);
        @(negedge clk);
        check("R5 next product", p, 8'd63);

        for (int x = 0; x < 16; x++) begin
            apply(x, 0);
            check("R3 b zero", p, 8'd0);
            apply(0, x);
            check("R3 a zero", p, 8'd0);
        end

        for (int x = 0; x < 16; x++) begin
            apply(x, 1);
            check("R4 b one", p, 8'(x));
            apply(1, x);
            check("R4 a one", p, 8'(x));
        end

        for (int i = 0; i < 4; i++) begin
            for (int x = 0; x < 16; x++) begin
                apply(x, 1 << i);
                check("R1 one-hot row", p, 8'(x << i));
            end
        end

        apply(15, 15);
        check("R7 full scale", p, 8'd225);
        apply(15, 8);
        check("R7 top row", p, 8'd120);

        apply(15, 3);
        check("R8 group carry", p, 8'd45);
        apply(11, 7);
        check("R8 group carry", p, 8'd77);
        apply(13, 13);
        check("R8 group carry", p, 8'd169);

        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                apply(x, y);
                check("R2 sweep", p, 8'(x * y));
            end
        end

        // R6: asynchronous clear in mid-run
        apply(9, 9);
        check("R2 before clear", p, 8'd81);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R6 async clear", p, 8'd0);
        @(negedge clk);
        check("R6 held in reset", p, 8'd0);
        rst_n = 1'b1;
        apply(6, 7);
        check("R2 after reset", p, 8'd42);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R2: got=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule